// File: doc/BRIEF.md
# Cable Driver Fault Flag and Output Power Control

This block is the control logic that sits beside a dual-output serial video line driver. It folds one input signal-presence indication and four output termination faults into a single fault request. Each of the five conditions has its own mask and polarity setting. The request drives an open-drain pin that is active low and can be shared by several drivers on one wire.

The same block also works out the operating state of the analog stages. It decides whether each output stage is powered down, and whether a lost input is handled by muting the outputs or by adding a small offset. It also picks the output edge rate from a board pin and a register bit. The signal-presence indication can be forced either way by software, and it can be tied into the power-down decision.

Only the fault request is registered, which removes glitches. Everything else is combinational from its inputs.

Top module: `sdi_drv_ctl`

## Requirements
- R1: The five fault sources are numbered as follows: source 0 is `los_raw` (1 means signal present), and sources 1 to 4 are `term_fault[0]` to `term_fault[3]`. With the mask and polarity bits all 0, a source is active when `los_raw` is 0 or when a termination fault is 1. `fault_pull` goes to 1 when any active source is unmasked.
- R2: Setting `fault_mask[k]` to 1 stops source k from ever setting `fault_pull`.
- R3: Setting `fault_dir[k]` to 1 swaps the level that makes source k active.
- R4: `fault_pull` is registered. After a rising clock edge it shows the sources, masks and polarity bits as they stood at that edge. It is 0 while `rst_n` is low.
- R5: While `en_pin` is 0, both bits of `drv_pd` are 1, whatever the other inputs are.
- R6: While `en_pin` is 1 and `los_pd_link` is 0, `drv_pd` equals `pd_req`.
- R7: While `en_pin` and `los_pd_link` are both 1, an effective signal loss sets both bits of `drv_pd` to 1. With the signal present, `drv_pd` equals `pd_req`.
- R8: With the effective signal lost, `mute` equals `mute_sel` and `offset_add` equals its inverse. With the signal present, both are 0.
- R9: The effective signal state is 0 when `force_los_off` is 1. Otherwise it is 1 when `force_los_on` is 1. Otherwise it is `los_raw`. `force_los_off` wins over `force_los_on`. `los_status` always equals `los_raw`.
- R10: `sd_rate` is 1 when `sd_pin` is 1. Otherwise it equals `sd_bit`.
- R11: The fault logic reads `los_raw` directly, so the force bits have no effect on `fault_pull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault request register |
| rst_n | input | 1 | Active-low asynchronous reset |
| los_raw | input | 1 | Signal detector output, 1 = signal present |
| term_fault | input | 4 | Termination faults: out0 true, out0 complement, out1 true, out1 complement |
| fault_mask | input | 5 | Per-source mask, 1 = removed from the flag |
| fault_dir | input | 5 | Per-source polarity swap |
| en_pin | input | 1 | Driver enable pin, 0 = power down all outputs |
| pd_req | input | 2 | Per-output power-down register bits |
| los_pd_link | input | 1 | Lets signal loss power down the outputs |
| mute_sel | input | 1 | 1 = mute on loss, 0 = add offset on loss |
| force_los_off | input | 1 | Treat the signal as never present |
| force_los_on | input | 1 | Treat the signal as always present |
| sd_pin | input | 1 | Edge-rate pin, 1 forces the slow edge rate |
| sd_bit | input | 1 | Edge-rate register bit, used when the pin is 0 |
| fault_pull | output | 1 | 1 = pull the open-drain fault pin low |
| drv_pd | output | 2 | Per-output power-down |
| mute | output | 1 | Mute the outputs |
| offset_add | output | 1 | Add anti-oscillation offset |
| sd_rate | output | 1 | 1 = slow edge rate selected |
| los_status | output | 1 | Reported signal detector state |

## Verification
The assertions assume that every input is a synchronous level that stays constant across a rising clock edge. The one-cycle fault check relies on this, because it compares the mask state at one edge with the flag at the next. The bench changes all inputs on the falling edge, one combination per cycle. This means no input ever moves near the sampling edge. The sweep covers every combination of source, mask and polarity, and every combination of the power and edge-rate controls. No asynchronous pulse is ever used.

// File: rtl/drv_ctl_pkg.sv
package drv_ctl_pkg;

  // Returns 1 when a source at level val counts as a live fault.
  function automatic logic src_hit(input logic val, input logic low_default,
                                   input logic dir, input logic mask);
    logic act_lvl;
    act_lvl = (~low_default) ^ dir;
    return (~mask) & (val == act_lvl);
  endfunction

  // Resolves the signal-presence state the control paths should use.
  function automatic logic los_resolve(input logic raw, input logic f_off,
                                       input logic f_on);
    if (f_off)     return 1'b0;
    else if (f_on) return 1'b1;
    else           return raw;
  endfunction

endpackage

// File: rtl/fault_merge.sv
module fault_merge
  import drv_ctl_pkg::*;
#(
  parameter int N_SRC = 5,
  parameter logic [N_SRC-1:0] LOW_DEF = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src,
  input  logic [N_SRC-1:0] mask,
  input  logic [N_SRC-1:0] dir,
  output logic [N_SRC-1:0] hit_vec,
  output logic             fault_pull
);

  genvar k;
  generate
    for (k = 0; k < N_SRC; k++) begin : g_src
      assign hit_vec[k] = src_hit(src[k], LOW_DEF[k], dir[k], mask[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_pull <= 1'b0;
    else        fault_pull <= |hit_vec;
  end

  // R2
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |=> !fault_pull);

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0) |=> !fault_pull);

endmodule

// File: rtl/los_policy.sv
module los_policy
  import drv_ctl_pkg::*;
(
  input  logic los_raw,
  input  logic force_off,
  input  logic force_on,
  input  logic mute_sel,
  output logic los_eff,
  output logic mute,
  output logic offset_add
);

  assign los_eff    = los_resolve(los_raw, force_off, force_on);
  assign mute       = ~los_eff & mute_sel;
  assign offset_add = ~los_eff & ~mute_sel;

endmodule

// File: rtl/drive_power.sv
module drive_power #(
  parameter int NUM_OUT = 2
) (
  input  logic               en_pin,
  input  logic               link_en,
  input  logic               los_eff,
  input  logic [NUM_OUT-1:0] pd_req,
  output logic [NUM_OUT-1:0] drv_pd
);

  logic global_off;
  assign global_off = ~en_pin | (link_en & ~los_eff);

  genvar o;
  generate
    for (o = 0; o < NUM_OUT; o++) begin : g_out
      assign drv_pd[o] = global_off | pd_req[o];
    end
  endgenerate

endmodule

// File: rtl/sdi_drv_ctl.sv
module sdi_drv_ctl #(
  parameter int NUM_OUT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 los_raw,
  input  logic [2*NUM_OUT-1:0] term_fault,
  input  logic [2*NUM_OUT:0]   fault_mask,
  input  logic [2*NUM_OUT:0]   fault_dir,
  input  logic                 en_pin,
  input  logic [NUM_OUT-1:0]   pd_req,
  input  logic                 los_pd_link,
  input  logic                 mute_sel,
  input  logic                 force_los_off,
  input  logic                 force_los_on,
  input  logic                 sd_pin,
  input  logic                 sd_bit,
  output logic                 fault_pull,
  output logic [NUM_OUT-1:0]   drv_pd,
  output logic                 mute,
  output logic                 offset_add,
  output logic                 sd_rate,
  output logic                 los_status
);

  localparam int N_TERM = 2 * NUM_OUT;
  localparam int N_SRC  = N_TERM + 1;
  localparam logic [N_SRC-1:0] LOW_DEF = {{N_TERM{1'b0}}, 1'b1};

  logic [N_SRC-1:0] src_vec;
  logic [N_SRC-1:0] hit_vec;
  logic             los_eff;

  assign src_vec = {term_fault, los_raw};

  fault_merge #(.N_SRC(N_SRC), .LOW_DEF(LOW_DEF)) u_fault (
    .clk(clk), .rst_n(rst_n), .src(src_vec), .mask(fault_mask),
    .dir(fault_dir), .hit_vec(hit_vec), .fault_pull(fault_pull)
  );

  los_policy u_los (
    .los_raw(los_raw), .force_off(force_los_off), .force_on(force_los_on),
    .mute_sel(mute_sel), .los_eff(los_eff), .mute(mute),
    .offset_add(offset_add)
  );

  drive_power #(.NUM_OUT(NUM_OUT)) u_pwr (
    .en_pin(en_pin), .link_en(los_pd_link), .los_eff(los_eff),
    .pd_req(pd_req), .drv_pd(drv_pd)
  );

  assign sd_rate    = sd_pin | sd_bit;
  assign los_status = los_raw;

  // R5
  disable_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |-> (&drv_pd));

  // R8
  mute_offset_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mute && offset_add));

  // R9
  force_off_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_los_off |-> (mute || offset_add));

  // R7
  link_loss_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && los_pd_link && (mute || offset_add)) |-> (&drv_pd));

endmodule

// File: tb/sdi_drv_ctl_tb.sv
module sdi_drv_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       los_raw = 1'b1;
  logic [3:0] term_fault = '0;
  logic [4:0] fault_mask = '0;
  logic [4:0] fault_dir = '0;
  logic       en_pin = 1'b1;
  logic [1:0] pd_req = '0;
  logic       los_pd_link = 1'b0;
  logic       mute_sel = 1'b0;
  logic       force_los_off = 1'b0;
  logic       force_los_on = 1'b0;
  logic       sd_pin = 1'b0;
  logic       sd_bit = 1'b0;
  logic       fault_pull;
  logic [1:0] drv_pd;
  logic       mute, offset_add, sd_rate, los_status;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdi_drv_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .los_raw(los_raw), .term_fault(term_fault),
    .fault_mask(fault_mask), .fault_dir(fault_dir), .en_pin(en_pin),
    .pd_req(pd_req), .los_pd_link(los_pd_link), .mute_sel(mute_sel),
    .force_los_off(force_los_off), .force_los_on(force_los_on),
    .sd_pin(sd_pin), .sd_bit(sd_bit), .fault_pull(fault_pull),
    .drv_pd(drv_pd), .mute(mute), .offset_add(offset_add),
    .sd_rate(sd_rate), .los_status(los_status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected flag: a source counts when it sits at its "bad" level.
  function automatic int exp_flag(input int s, input int m, input int d);
    int bad;
    bad = (s ^ 5'b00001) ^ d;   // LOS is bad when low, the rest when high
    return ((bad & ~m & 5'h1f) != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: reset holds the flag inactive even with a live fault present
    los_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 reset", fault_pull, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 first edge", fault_pull, 1);
    los_raw = 1'b1;
    @(negedge clk);
    chk("R4 clear", fault_pull, 0);

    // R1/R2/R3 sweep over every source, mask and polarity setting
    for (int i = 0; i < 32768; i++) begin
      int s, m, d;
      s = i & 31; m = (i >> 5) & 31; d = (i >> 10) & 31;
      los_raw = s[0]; term_fault = s[4:1];
      fault_mask = m[4:0]; fault_dir = d[4:0];
      @(negedge clk);
      if (m == 0 && d == 0)  chk("R1", fault_pull, exp_flag(s, m, d));
      else if (d == 0)       chk("R2", fault_pull, exp_flag(s, m, d));
      else                   chk("R3", fault_pull, exp_flag(s, m, d));
    end

    // R11: force bits leave the flag tied to the raw detector
    fault_mask = 5'b11110; fault_dir = '0; term_fault = '0;
    los_raw = 1'b0; force_los_on = 1'b1;
    @(negedge clk);
    chk("R11 force on", fault_pull, 1);
    los_raw = 1'b1; force_los_on = 1'b0; force_los_off = 1'b1;
    @(negedge clk);
    chk("R11 force off", fault_pull, 0);
    force_los_off = 1'b0;

    // R5..R10 sweep of the power, mute and edge-rate controls
    for (int j = 0; j < 1024; j++) begin
      int eff, epd, emute, eoff;
      @(negedge clk);
      en_pin = j[0]; pd_req = j[2:1]; los_pd_link = j[3];
      mute_sel = j[4]; force_los_off = j[5]; force_los_on = j[6];
      los_raw = j[7]; sd_pin = j[8]; sd_bit = j[9];
      #1;
      eff = j[5] ? 0 : (j[6] ? 1 : int'(j[7]));
      if (!j[0])               epd = 3;
      else if (j[3] && !eff)   epd = 3;
      else                     epd = (j >> 1) & 3;
      emute = (!eff && j[4]) ? 1 : 0;
      eoff  = (!eff && !j[4]) ? 1 : 0;
      if (!j[0])      chk("R5", drv_pd, epd);
      else if (!j[3]) chk("R6", drv_pd, epd);
      else            chk("R7", drv_pd, epd);
      if (j[5] || j[6]) begin
        chk("R9 mute", mute, emute);
        chk("R9 offset", offset_add, eoff);
      end else begin
        chk("R8 mute", mute, emute);
        chk("R8 offset", offset_add, eoff);
      end
      chk("R9 status", los_status, j[7]);
      chk("R10", sd_rate, (j[8] || j[9]) ? 1 : 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule